// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over several clock cycles and returns a signed product twice as wide. It recodes the multiplier one bit pair at a time (radix 2). Each pair tells the datapath whether to add the multiplicand to the running partial product, subtract it, or leave it alone. A combined arithmetic right shift of the partial product, the multiplier and a saved outgoing bit then follows. Because the shift extends the sign, negative operands need no separate sign correction.

A caller waits for `ready_o` high, presents the operands and pulses `start_i`. It then waits for `ready_o` to return high and reads `prod_o`. The product stays on the output until the next accepted start. Operands are `OP_W = MAG_W + 1` bits wide: a magnitude of `MAG_W` bits plus a sign bit. The partial-product register carries one extra guard bit, so subtracting the most negative multiplicand cannot overflow.

Top module: `booth_mul`

## Requirements
- R1: While `rst_ni` is low and directly after reset, `ready_o` is 1 and `prod_o` is all zeros.
- R2: A `start_i` sampled high while `ready_o` is high is accepted. `ready_o` is 0 from the next cycle on, for exactly `OP_W` cycles. It is 1 again after the `OP_W`-th clock edge following the accepting edge.
- R3: A `start_i` sampled while `ready_o` is 0 is ignored. The running result and its completion time are unchanged.
- R4: When `ready_o` returns high, `prod_o` equals the signed product `a_i * b_i` of the operands sampled at the accepting edge. This holds for every operand pair, including the most negative value on either input or on both.
- R5: Each step recodes the pair (multiplier LSB, saved bit). The pair (1,0) subtracts the multiplicand from the partial product. The pair (0,1) adds it. The pairs (0,0) and (1,1) leave the partial product unchanged.
- R6: Each step shifts the partial product, multiplier and saved bit right as one register. The vacated top bit copies the partial-product sign, and the bit leaving the multiplier becomes the new saved bit.
- R7: The saved bit is cleared at every accepted start. A result therefore does not depend on the previous operation, including one whose multiplier was -1.
- R8: While `ready_o` is high and no start is sampled, `prod_o` holds its value, even if `a_i` and `b_i` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication; taken only while `ready_o` is 1 |
| a_i | input | OP_W | Signed multiplicand |
| b_i | input | OP_W | Signed multiplier |
| ready_o | output | 1 | Idle and result valid |
| prod_o | output | 2*OP_W | Signed product, `{partial product, multiplier}` |

## Verification
The operands are loaded at the accepting edge, and each of the next `OP_W` edges performs one recode-and-shift step. The result and `ready_o` high are therefore due one falling edge after the `OP_W`-th edge. The bench drives inputs on falling edges and counts edges from the accepting one. It confirms `ready_o` is still 0 after the `(OP_W-1)`-th step, then samples the product at the falling edge after the last step. Hold checks sample `prod_o` on several later falling edges with changed operands and no start.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic      q0_i,
  input  logic      qe_i,
  output booth_op_e op_o
);
  // R5: run start subtracts, run end adds, inside a run nothing
  always_comb begin
    unique case ({q0_i, qe_i})
      2'b10:   op_o = OP_SUB;
      2'b01:   op_o = OP_ADD;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int OP_W = 5,
  parameter int P_W  = OP_W + 1
) (
  input  logic [P_W-1:0]  p_i,
  input  logic [OP_W-1:0] m_i,
  input  booth_op_e       op_i,
  output logic [P_W-1:0]  sum_o
);
  localparam int EXT_W = P_W - OP_W;

  logic [P_W-1:0] m_ext;
  assign m_ext = {{EXT_W{m_i[OP_W-1]}}, m_i};

  // subtraction adds the two's complement; carry out dropped
  always_comb begin
    unique case (op_i)
      OP_ADD:  sum_o = p_i + m_ext;
      OP_SUB:  sum_o = p_i + ~m_ext + P_W'(1);
      default: sum_o = p_i;
    endcase
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int OP_W = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic load_o,
  output logic step_o
);
  localparam int CNT_W = $clog2(OP_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign ready_o = ~busy_q;
  assign load_o  = start_i & ~busy_q;
  assign step_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= LAST);

  // R2
  ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);

  // R3
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != LAST) |=> busy_q);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int MAG_W = 4,
  parameter int OP_W  = MAG_W + 1,
  parameter int PR_W  = 2 * OP_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            ready_o,
  output logic [PR_W-1:0] prod_o
);
  localparam int P_W = OP_W + 1;  // guard bit for the most negative multiplicand

  logic            load, step;
  logic [OP_W-1:0] m_r, q_r;
  logic [P_W-1:0]  p_r, sum;
  logic            qe_r;
  booth_op_e       op;

  booth_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ready_o (ready_o),
    .load_o  (load),
    .step_o  (step)
  );

  booth_recoder u_rec (
    .q0_i (q_r[0]),
    .qe_i (qe_r),
    .op_o (op)
  );

  booth_addsub #(.OP_W(OP_W), .P_W(P_W)) u_as (
    .p_i   (p_r),
    .m_i   (m_r),
    .op_i  (op),
    .sum_o (sum)
  );

  // R6: {P,Q,Qe} shifted right as one, sign copied in
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_r  <= '0;
      q_r  <= '0;
      p_r  <= '0;
      qe_r <= 1'b0;
    end else if (load) begin
      m_r  <= a_i;
      q_r  <= b_i;
      p_r  <= '0;
      qe_r <= 1'b0;  // R7
    end else if (step) begin
      p_r  <= {sum[P_W-1], sum[P_W-1:1]};
      q_r  <= {sum[0], q_r[OP_W-1:1]};
      qe_r <= q_r[0];
    end
  end

  assign prod_o = {p_r[OP_W-1:0], q_r};

  // R6
  qe_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> qe_r == $past(q_r[0]));

  // R6
  sign_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> p_r[P_W-1] == p_r[P_W-2]);

  // R4
  guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> p_r[P_W-1] == p_r[OP_W-1]);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> $stable(prod_o));

  // R7
  qe_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !qe_r);
endmodule

// File: tb/sim_booth_mul.sv
module sim_booth_mul;
  localparam int MAG_W = 4;
  localparam int OP_W  = MAG_W + 1;
  localparam int PR_W  = 2 * OP_W;
  localparam int LO    = -(1 << (OP_W - 1));
  localparam int HI    = (1 << (OP_W - 1)) - 1;
  localparam int NVEC  = 8;
  localparam int WDOG  = 150000;

  // {a, b, expected}
  localparam int VEC [NVEC][3] = '{
    '{-12, -11, 132}, '{12, 11, 132}, '{-12, 11, -132}, '{LO, LO, LO * LO},
    '{LO, HI, LO * HI}, '{HI, HI, HI * HI}, '{0, LO, 0}, '{-1, -1, 1}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [OP_W-1:0] a = '0, b = '0;
  logic            ready;
  logic [PR_W-1:0] prod;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  booth_mul #(.MAG_W(MAG_W)) u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .a_i     (a),
    .b_i     (b),
    .ready_o (ready),
    .prod_o  (prod)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sprod(input logic [PR_W-1:0] v);
    return longint'($signed(v));
  endfunction

  // one operation; optional stray start while busy (R3)
  task automatic run_op(input int ia, input int ib, input bit stray, input string req);
    @(negedge clk);
    a = ia[OP_W-1:0];
    b = ib[OP_W-1:0];
    start = 1'b1;
    @(negedge clk);  // accepting edge passed
    start = 1'b0;
    chk("R2 ready low after start", ready, 0);
    if (stray) begin
      a = HI[OP_W-1:0];
      b = LO[OP_W-1:0];
      start = 1'b1;
    end
    for (int j = 1; j < OP_W; j++) begin
      @(negedge clk);
      start = 1'b0;
    end
    chk("R2 ready low before last step", ready, 0);
    @(negedge clk);
    chk("R2 ready high after last step", ready, 1);
    chk(req, sprod(prod), longint'(ia) * longint'(ib));
  endtask

  initial begin
    #1;
    chk("R1 ready in reset", ready, 1);
    chk("R1 product in reset", prod, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", ready, 1);
    chk("R1 product after reset", prod, 0);

    // R4 R5 directed table
    for (int v = 0; v < NVEC; v++) begin
      run_op(VEC[v][0], VEC[v][1], 1'b0, "R4 R5 table product");
      chk("R4 table expected", sprod(prod), VEC[v][2]);
    end

    // R4 R6 exhaustive signed range
    for (int i = LO; i <= HI; i++)
      for (int j = LO; j <= HI; j++)
        run_op(i, j, 1'b0, "R4 R6 exhaustive product");

    // R3 start while busy ignored
    run_op(-7, 9, 1'b1, "R3 stray start ignored");
    chk("R3 no restart", ready, 1);

    // R7 saved bit cleared: after multiplier -1, an even multiplier
    run_op(5, -1, 1'b0, "R7 first op");
    run_op(3, 6, 1'b0, "R7 op after -1 multiplier");
    run_op(LO, -1, 1'b0, "R7 most negative times -1");
    run_op(-3, 2, 1'b0, "R7 op after most negative");

    // R8 hold without start
    run_op(-13, 7, 1'b0, "R8 setup");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      a = k[OP_W-1:0];
      b = ~k[OP_W-1:0];
      @(negedge clk);
      chk("R8 product held", sprod(prod), -91);
      chk("R8 ready held", ready, 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule